// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave Engine

This block is a synthesizable behavioural model of a serial EEPROM that answers on a two-wire bus. It runs on a fast system clock. It samples the clock line and the data line through synchronizers and pulls the data line low through an open-drain enable. It stores 512 bytes in registers and supports five operations: single-byte writes, writes of up to one 16-byte page, reads from the current address, reads from a random address, and sequential reads that run on for as long as the master keeps acknowledging.

Written bytes are first gathered in a page-sized staging buffer. They are stored only when the master closes the transfer with a stop condition, and each store starts a timed busy period. During that period the device does not answer its own address, so a master can poll with acknowledge requests to learn when the write has finished. A write-protect input locks the upper half of the array. The busy period is a parameter in system clock cycles, so simulations can keep it short.

Top module: `serial_eeprom_slave`

## Requirements
- R1: A falling data line while the clock line is high (start) aborts any transfer and begins a new device-address byte. A rising data line while the clock is high (stop) ends the transfer. A repeated start without a stop is accepted.
- R2: The first byte after a start is accepted only when its bits 7..4 are 1010 and its bits 3..2 equal the `hw_sel` pins. Bit 1 becomes word-address bit 8 when a word address follows, and bit 0 selects a read (1) or a write (0). On a mismatch the device does not acknowledge and ignores the bus until the next start.
- R3: Each accepted byte is acknowledged by holding the data line low through the ninth clock pulse. `sda_oe` changes only while the synchronized clock line is low, and it is low whenever the engine is idle.
- R4: Data bytes of a write reach the array only when a stop ends that write. If a repeated start comes first, the staged bytes are discarded and no busy period starts.
- R5: After each written data byte, only the low 4 bits of the word address advance. Bits 8..4 stay fixed, so a 17th or later byte wraps to the start of the same 16-byte page and overwrites the bytes staged there.
- R6: A read with no word address returns the byte at the internal pointer, which holds the last address accessed plus one.
- R7: During a read, each master acknowledge (data low in the ninth clock) makes the device send the next byte. The pointer advances across the whole array and wraps from 511 to 0. A master non-acknowledge followed by a stop ends the read.
- R8: A write that carries a word address but no data bytes only loads the pointer and starts no busy period. Together with a repeated start and a read, this makes a random read.
- R9: A stored write makes the device refuse its device address for `WR_CYCLES` system clocks. After that period it acknowledges again.
- R10: While `wp_i` is high, writes aimed at word addresses with bit 8 set are acknowledged but not stored and start no busy period. Writes to the lower half are stored normally. While `wp_i` is low, both halves accept writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than the bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin (the wired level) |
| sda_oe | output | 1 | 1 pulls the data line low |
| sda_o | output | 1 | Output level of the open-drain driver, tied low |
| hw_sel | input | HW_BITS (2) | Hard-wired device address bits compared with bits 3..2 of the address byte |
| wp_i | input | 1 | Write protect for the upper half of the array |

## Verification
The write path is driven with a single byte, with an 18-byte burst that crosses its page boundary, and with a staged write that a repeated start cuts off. Together these separate commit-on-stop from early storage, and page-local wrapping from linear address counting. Reads are run as random, current-address and multi-byte sequential transfers, including one that starts at address 511. The results show whether the pointer keeps the last address plus one and wraps across the whole array rather than within a page. Two cells that differ only in word-address bit 8 are written and read back to show that the page-select bit reaches the array. Acknowledge polling right after stored, address-only, discarded and write-protected writes separates the cases that start the busy period from those that must not.

// File: rtl/eep_pkg.sv
package eep_pkg;

  // Protocol phase of the slave engine
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_RX,
    PH_RXACK,
    PH_TX,
    PH_TXACK
  } phase_e;

  // Meaning of the byte currently being received
  typedef enum logic [1:0] {
    BK_DEV,
    BK_WADDR,
    BK_DATA
  } byte_e;

  localparam logic [3:0] DEV_TYPE = 4'b1010;

endpackage

// File: rtl/eep_line_sync.sv
module eep_line_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_lvl,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt
);

  localparam int LINES = 2;

  logic [LINES-1:0] raw;
  logic [LINES-1:0] stab;
  logic [LINES-1:0] prev;

  assign raw = {scl_i, sda_i};

  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic [SYNC_STAGES-1:0] pipe;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pipe <= '1;
      else        pipe <= {pipe[SYNC_STAGES-2:0], raw[g]};
    end
    assign stab[g] = pipe[SYNC_STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= '1;
    else        prev <= stab;
  end

  assign scl_lvl   = stab[1];
  assign sda_lvl   = stab[0];
  assign scl_rise  = stab[1] & ~prev[1];
  assign scl_fall  = ~stab[1] & prev[1];
  assign start_evt = stab[1] & prev[1] & prev[0] & ~stab[0];
  assign stop_evt  = stab[1] & prev[1] & ~prev[0] & stab[0];

endmodule

// File: rtl/eep_store.sv
module eep_store #(
  parameter int MEM_BYTES  = 512,
  parameter int PAGE_BYTES = 16
) (
  input  logic                                   clk,
  input  logic                                   wr_en,
  input  logic [$clog2(MEM_BYTES)-$clog2(PAGE_BYTES)-1:0] wr_page,
  input  logic [PAGE_BYTES*8-1:0]                wr_data,
  input  logic [PAGE_BYTES-1:0]                  wr_mask,
  input  logic [$clog2(MEM_BYTES)-1:0]           rd_addr,
  output logic [7:0]                             rd_data
);

  localparam int PW = $clog2(PAGE_BYTES);

  logic [7:0] mem [MEM_BYTES];

  // One page-wide write port: every staged byte of the page lands together
  always_ff @(posedge clk) begin
    if (wr_en) begin
      for (int b = 0; b < PAGE_BYTES; b++) begin
        if (wr_mask[b]) mem[{wr_page, b[PW-1:0]}] <= wr_data[b*8 +: 8];
      end
    end
  end

  assign rd_data = mem[rd_addr];

endmodule

// File: rtl/eep_proto.sv
module eep_proto
  import eep_pkg::*;
#(
  parameter int MEM_BYTES  = 512,
  parameter int PAGE_BYTES = 16,
  parameter int WR_CYCLES  = 1000,
  parameter int HW_BITS    = 2
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               sda_lvl,
  input  logic                               scl_rise,
  input  logic                               scl_fall,
  input  logic                               start_evt,
  input  logic                               stop_evt,
  input  logic [HW_BITS-1:0]                 hw_sel,
  input  logic                               wp_i,
  input  logic [7:0]                         rd_data,
  output logic                               sda_oe,
  output logic [$clog2(MEM_BYTES)-1:0]       rd_addr,
  output logic                               wr_en,
  output logic [$clog2(MEM_BYTES)-$clog2(PAGE_BYTES)-1:0] wr_page,
  output logic [PAGE_BYTES*8-1:0]            wr_data,
  output logic [PAGE_BYTES-1:0]              wr_mask,
  output logic                               busy,
  output phase_e                             phase,
  output byte_e                              kind
);

  localparam int AW   = $clog2(MEM_BYTES);
  localparam int PW   = $clog2(PAGE_BYTES);
  localparam int SELW = AW - 8;
  localparam int CW   = $clog2(WR_CYCLES + 1);

  phase_e                 phase_n;
  byte_e                  kind_n;
  logic [3:0]             cnt, cnt_n;
  logic [7:0]             shreg, shreg_n;
  logic [6:0]             txreg, txreg_n;
  logic                   rw, rw_n;
  logic                   mack, mack_n;
  logic [SELW-1:0]        psel, psel_n;
  logic [AW-1:0]          ptr, ptr_n;
  logic                   oe, oe_n;
  logic [PAGE_BYTES*8-1:0] pbuf, pbuf_n;
  logic [PAGE_BYTES-1:0]  pmask, pmask_n;
  logic [CW-1:0]          bcnt, bcnt_n;
  logic                   dev_match;
  logic                   blocked;

  assign busy      = (bcnt != '0);
  assign dev_match = (shreg[7:4] == DEV_TYPE) && (shreg[3 -: HW_BITS] == hw_sel) && !busy;
  assign blocked   = wp_i && ptr[AW-1];

  // Next-state logic
  always_comb begin
    phase_n = phase;
    kind_n  = kind;
    cnt_n   = cnt;
    shreg_n = shreg;
    txreg_n = txreg;
    rw_n    = rw;
    mack_n  = mack;
    psel_n  = psel;
    ptr_n   = ptr;
    oe_n    = oe;
    pbuf_n  = pbuf;
    pmask_n = pmask;
    bcnt_n  = bcnt;
    wr_en   = 1'b0;

    if (busy) bcnt_n = bcnt - 1'b1;

    if (stop_evt) begin
      phase_n = PH_IDLE;
      oe_n    = 1'b0;
      pmask_n = '0;
      if ((pmask != '0) && !blocked) begin
        wr_en  = 1'b1;
        bcnt_n = CW'(WR_CYCLES);
      end
    end else if (start_evt) begin
      phase_n = PH_RX;
      kind_n  = BK_DEV;
      cnt_n   = '0;
      oe_n    = 1'b0;
      pmask_n = '0;
    end else begin
      unique case (phase)
        PH_RX: begin
          if (scl_rise && cnt != 4'd8) begin
            shreg_n = {shreg[6:0], sda_lvl};
            cnt_n   = cnt + 4'd1;
          end else if (scl_fall && cnt == 4'd8) begin
            cnt_n = '0;
            unique case (kind)
              BK_DEV: begin
                if (dev_match) begin
                  psel_n  = shreg[SELW:1];
                  rw_n    = shreg[0];
                  oe_n    = 1'b1;
                  phase_n = PH_RXACK;
                end else begin
                  phase_n = PH_IDLE;
                end
              end
              BK_WADDR: begin
                ptr_n   = {psel, shreg};
                oe_n    = 1'b1;
                phase_n = PH_RXACK;
              end
              default: begin
                pbuf_n[ptr[PW-1:0]*8 +: 8] = shreg;
                pmask_n[ptr[PW-1:0]]       = 1'b1;
                ptr_n[PW-1:0]              = ptr[PW-1:0] + 1'b1;
                oe_n                       = 1'b1;
                phase_n                    = PH_RXACK;
              end
            endcase
          end
        end
        PH_RXACK: begin
          if (scl_fall) begin
            cnt_n = '0;
            if (kind == BK_DEV && rw) begin
              txreg_n = rd_data[6:0];
              oe_n    = ~rd_data[7];
              phase_n = PH_TX;
            end else begin
              oe_n    = 1'b0;
              phase_n = PH_RX;
              kind_n  = (kind == BK_DEV) ? BK_WADDR : BK_DATA;
            end
          end
        end
        PH_TX: begin
          if (scl_fall) begin
            if (cnt == 4'd7) begin
              oe_n    = 1'b0;
              phase_n = PH_TXACK;
              ptr_n   = ptr + 1'b1;
            end else begin
              cnt_n   = cnt + 4'd1;
              oe_n    = ~txreg[6];
              txreg_n = {txreg[5:0], 1'b0};
            end
          end
        end
        PH_TXACK: begin
          if (scl_rise) begin
            mack_n = ~sda_lvl;
          end else if (scl_fall) begin
            cnt_n = '0;
            if (mack) begin
              txreg_n = rd_data[6:0];
              oe_n    = ~rd_data[7];
              phase_n = PH_TX;
            end else begin
              phase_n = PH_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  // Control registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_IDLE;
      kind  <= BK_DEV;
      cnt   <= '0;
      shreg <= '0;
      txreg <= '0;
      rw    <= 1'b0;
      mack  <= 1'b0;
      psel  <= '0;
      ptr   <= '0;
      oe    <= 1'b0;
      pmask <= '0;
      bcnt  <= '0;
    end else begin
      phase <= phase_n;
      kind  <= kind_n;
      cnt   <= cnt_n;
      shreg <= shreg_n;
      txreg <= txreg_n;
      rw    <= rw_n;
      mack  <= mack_n;
      psel  <= psel_n;
      ptr   <= ptr_n;
      oe    <= oe_n;
      pmask <= pmask_n;
      bcnt  <= bcnt_n;
    end
  end

  // Staging data path, qualified by its mask and therefore left without reset
  always_ff @(posedge clk) begin
    pbuf <= pbuf_n;
  end

  assign sda_oe  = oe;
  assign rd_addr = ptr;
  assign wr_page = ptr[AW-1:PW];
  assign wr_data = pbuf;
  assign wr_mask = pmask;

endmodule

// File: rtl/serial_eeprom_slave.sv
module serial_eeprom_slave
  import eep_pkg::*;
#(
  parameter int MEM_BYTES   = 512,
  parameter int PAGE_BYTES  = 16,
  parameter int WR_CYCLES   = 1000,
  parameter int SYNC_STAGES = 2,
  parameter int HW_BITS     = 3 - ($clog2(MEM_BYTES) - 8)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               scl_i,
  input  logic               sda_i,
  output logic               sda_oe,
  output logic               sda_o,
  input  logic [HW_BITS-1:0] hw_sel,
  input  logic               wp_i
);

  localparam int AW = $clog2(MEM_BYTES);
  localparam int PW = $clog2(PAGE_BYTES);

  logic [1:0]              rst_pipe;
  logic                    rst_sync_n;
  logic                    scl_lvl, sda_lvl, scl_rise, scl_fall, start_evt, stop_evt;
  logic [AW-1:0]           rd_addr;
  logic [7:0]              rd_data;
  logic                    wr_en;
  logic [AW-PW-1:0]        wr_page;
  logic [PAGE_BYTES*8-1:0] wr_data;
  logic [PAGE_BYTES-1:0]   wr_mask;
  logic                    busy;
  phase_e                  phase;
  byte_e                   kind;

  // Reset asserts at once and leaves on a clock edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  eep_line_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .scl_lvl   (scl_lvl),
    .sda_lvl   (sda_lvl),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_evt (start_evt),
    .stop_evt  (stop_evt)
  );

  eep_proto #(
    .MEM_BYTES  (MEM_BYTES),
    .PAGE_BYTES (PAGE_BYTES),
    .WR_CYCLES  (WR_CYCLES),
    .HW_BITS    (HW_BITS)
  ) u_proto (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .sda_lvl   (sda_lvl),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_evt (start_evt),
    .stop_evt  (stop_evt),
    .hw_sel    (hw_sel),
    .wp_i      (wp_i),
    .rd_data   (rd_data),
    .sda_oe    (sda_oe),
    .rd_addr   (rd_addr),
    .wr_en     (wr_en),
    .wr_page   (wr_page),
    .wr_data   (wr_data),
    .wr_mask   (wr_mask),
    .busy      (busy),
    .phase     (phase),
    .kind      (kind)
  );

  eep_store #(
    .MEM_BYTES  (MEM_BYTES),
    .PAGE_BYTES (PAGE_BYTES)
  ) u_store (
    .clk     (clk),
    .wr_en   (wr_en),
    .wr_page (wr_page),
    .wr_data (wr_data),
    .wr_mask (wr_mask),
    .rd_addr (rd_addr),
    .rd_data (rd_data)
  );

  assign sda_o = 1'b0;

endmodule

// File: rtl/eep_slave_checker.sv
module eep_slave_checker
  import eep_pkg::*;
#(
  parameter int AW         = 9,
  parameter int PAGE_BYTES = 16
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  scl_lvl,
  input logic                  sda_oe,
  input logic                  busy,
  input logic                  wr_en,
  input logic [PAGE_BYTES-1:0] wr_mask,
  input phase_e                phase,
  input byte_e                 kind,
  input logic [AW-1:0]         rd_addr
);

  localparam int PW = $clog2(PAGE_BYTES);

  assert_oe_moves_scl_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !scl_lvl);

  assert_idle_released_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_IDLE) |-> !sda_oe);

  assert_no_dev_ack_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !(phase == PH_RXACK && kind == BK_DEV));

  assert_store_starts_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> busy);

  assert_stage_empty_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (wr_mask == '0));

  assert_page_fixed_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (phase != PH_IDLE && kind == BK_DATA && $past(kind == BK_DATA))
      |-> (rd_addr[AW-1:PW] == $past(rd_addr[AW-1:PW])));

endmodule

bind serial_eeprom_slave eep_slave_checker #(
  .AW         (AW),
  .PAGE_BYTES (PAGE_BYTES)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_sync_n),
  .scl_lvl (scl_lvl),
  .sda_oe  (sda_oe),
  .busy    (busy),
  .wr_en   (wr_en),
  .wr_mask (wr_mask),
  .phase   (phase),
  .kind    (kind),
  .rd_addr (rd_addr)
);

// File: tb/serial_eeprom_slave_tb.sv
module serial_eeprom_slave_tb;

  localparam int WR_CYC = 1000;
  localparam logic [1:0] HW = 2'b10;

  logic clk;
  logic rst_n;
  logic scl_m;
  logic sda_m;
  logic wp;
  wire  sda_oe;
  wire  sda_o;
  wire  sda_bus = sda_m & ~sda_oe;

  int checks;
  int fails;

  logic [7:0] exp_q [$];
  string      tag_q [$];
  logic [7:0] act_q [$];

  serial_eeprom_slave #(.WR_CYCLES(WR_CYC)) u_dut (
    .clk    (clk),
    .rst_n  (rst_n),
    .scl_i  (scl_m),
    .sda_i  (sda_bus),
    .sda_oe (sda_oe),
    .sda_o  (sda_o),
    .hw_sel (HW),
    .wp_i   (wp)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic logic [7:0] dev(input logic p, input logic rd);
    return {4'b1010, HW, p, rd};
  endfunction

  task automatic check_bit(input logic got, input logic exp, input string tag);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %0b expected %0b", tag, got, exp);
    end
  endtask

  task automatic expect_byte(input logic [7:0] v, input string tag);
    exp_q.push_back(v);
    tag_q.push_back(tag);
  endtask

  // Scoreboard monitor: pairs each byte read from the bus with the oldest expectation
  initial begin
    forever begin
      @(negedge clk);
      while (act_q.size() > 0) begin
        logic [7:0] a;
        a = act_q.pop_front();
        checks++;
        if (exp_q.size() == 0) begin
          fails++;
          $display("FAIL unexpected read: got %02h expected none", a);
        end else begin
          logic [7:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          if (a !== e) begin
            fails++;
            $display("FAIL %s: got %02h expected %02h", t, a, e);
          end
        end
      end
    end
  end

  task automatic q_wait();
    repeat (10) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; q_wait();
    scl_m = 1'b1; q_wait();
    sda_m = 1'b0; q_wait();
    scl_m = 1'b0; q_wait();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; q_wait();
    scl_m = 1'b1; q_wait();
    sda_m = 1'b1; q_wait();
  endtask

  task automatic put_byte(input logic [7:0] b, output logic acked);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; q_wait();
      scl_m = 1'b1; q_wait(); q_wait();
      scl_m = 1'b0; q_wait();
    end
    sda_m = 1'b1; q_wait();
    scl_m = 1'b1; q_wait();
    acked = !sda_bus; q_wait();
    scl_m = 1'b0; q_wait();
  endtask

  task automatic get_byte(input logic give_ack);
    logic [7:0] b;
    b = '0;
    sda_m = 1'b1;
    for (int i = 0; i < 8; i++) begin
      q_wait();
      scl_m = 1'b1; q_wait();
      b = {b[6:0], sda_bus}; q_wait();
      scl_m = 1'b0;
    end
    sda_m = give_ack ? 1'b0 : 1'b1; q_wait();
    scl_m = 1'b1; q_wait(); q_wait();
    scl_m = 1'b0; q_wait();
    sda_m = 1'b1;
    act_q.push_back(b);
  endtask

  task automatic do_write(input logic p, input logic [7:0] a, input logic [7:0] first,
                          input int n, input string tag);
    logic ak;
    bus_start();
    put_byte(dev(p, 1'b0), ak); check_bit(ak, 1'b1, {tag, " device ack"});
    put_byte(a, ak);            check_bit(ak, 1'b1, {tag, " address ack"});
    for (int i = 0; i < n; i++) begin
      put_byte(first + 8'(i), ak); check_bit(ak, 1'b1, {tag, " data ack"});
    end
    bus_stop();
  endtask

  // Random read when rnd is set, otherwise current-address read; n bytes
  task automatic do_read(input logic rnd, input logic p, input logic [7:0] a,
                         input int n, input string tag);
    logic ak;
    bus_start();
    if (rnd) begin
      put_byte(dev(p, 1'b0), ak); check_bit(ak, 1'b1, {tag, " dummy write ack"});
      put_byte(a, ak);            check_bit(ak, 1'b1, {tag, " address ack"});
      bus_start();
    end
    put_byte(dev(p, 1'b1), ak); check_bit(ak, 1'b1, {tag, " read device ack"});
    for (int i = 0; i < n; i++) get_byte(i < n - 1);
    bus_stop();
  endtask

  task automatic poll(input logic exp_ack, input string tag);
    logic ak;
    bus_start();
    put_byte(dev(1'b0, 1'b0), ak);
    check_bit(ak, exp_ack, tag);
    bus_stop();
  endtask

  task automatic wait_write();
    repeat (WR_CYC + 200) @(negedge clk);
  endtask

  // Watchdog
  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic ak;
    checks = 0;
    fails  = 0;
    rst_n  = 1'b0;
    scl_m  = 1'b1;
    sda_m  = 1'b1;
    wp     = 1'b0;
    repeat (5) @(negedge clk);
    check_bit(sda_oe, 1'b0, "R3 reset release");
    rst_n = 1'b1;
    repeat (10) @(negedge clk);
    check_bit(sda_oe, 1'b0, "R3 idle after reset");

    // R2: wrong hard-wired bits are not acknowledged
    bus_start();
    put_byte({4'b1010, 2'b01, 1'b0, 1'b0}, ak);
    check_bit(ak, 1'b0, "R2 mismatched address nack");
    bus_stop();
    bus_start();
    put_byte({4'b1011, HW, 1'b0, 1'b0}, ak);
    check_bit(ak, 1'b0, "R2 wrong type nibble nack");
    bus_stop();

    // R9: byte write, polling while busy and after
    do_write(1'b0, 8'h10, 8'hA5, 1, "R9 byte write");
    poll(1'b0, "R9 poll during write cycle");
    wait_write();
    poll(1'b1, "R9 poll after write cycle");

    // R1 and R8: random read through a repeated start
    expect_byte(8'hA5, "R1 R8 random read");
    do_read(1'b1, 1'b0, 8'h10, 1, "R8");

    // R8: address-only write starts no busy period
    bus_start();
    put_byte(dev(1'b0, 1'b0), ak); check_bit(ak, 1'b1, "R8 device ack");
    put_byte(8'h10, ak);           check_bit(ak, 1'b1, "R8 address ack");
    bus_stop();
    poll(1'b1, "R8 no write cycle");

    // R5: 18 bytes from 0x2E wrap inside page 0x20..0x2F
    do_write(1'b0, 8'h2E, 8'h40, 18, "R5 page write");
    wait_write();
    expect_byte(8'h42, "R5 page start after wrap");
    do_read(1'b1, 1'b0, 8'h20, 1, "R5");
    // R6: current address is last accessed plus one
    expect_byte(8'h43, "R6 current address read");
    do_read(1'b0, 1'b0, 8'h00, 1, "R6");
    // R7: sequential read over the whole page
    for (int i = 0; i < 14; i++) expect_byte(8'h42 + 8'(i), "R7 sequential read");
    expect_byte(8'h50, "R5 overwritten byte 0x2E");
    expect_byte(8'h51, "R5 overwritten byte 0x2F");
    do_read(1'b1, 1'b0, 8'h20, 16, "R7");

    // R4: staged data cut off by a repeated start is dropped
    do_write(1'b0, 8'h05, 8'h11, 1, "R4 setup write");
    wait_write();
    bus_start();
    put_byte(dev(1'b0, 1'b0), ak); check_bit(ak, 1'b1, "R4 device ack");
    put_byte(8'h05, ak);           check_bit(ak, 1'b1, "R4 address ack");
    put_byte(8'h77, ak);           check_bit(ak, 1'b1, "R4 data ack");
    expect_byte(8'h11, "R4 discarded write");
    do_read(1'b1, 1'b0, 8'h05, 1, "R4");
    poll(1'b1, "R4 no write cycle after discard");

    // R2 page bit and R7 wrap from 511 to 0
    do_write(1'b1, 8'hFF, 8'hC3, 1, "R2 upper write");
    wait_write();
    do_write(1'b0, 8'hFF, 8'h7E, 1, "R2 lower write");
    wait_write();
    do_write(1'b0, 8'h00, 8'h3C, 1, "R7 zero write");
    wait_write();
    expect_byte(8'hC3, "R2 page bit selects 0x1FF");
    expect_byte(8'h3C, "R7 wrap to address 0");
    do_read(1'b1, 1'b1, 8'hFF, 2, "R7");
    expect_byte(8'h7E, "R2 page bit clear selects 0x0FF");
    do_read(1'b1, 1'b0, 8'hFF, 1, "R2");

    // R10: write protection of the upper half
    do_write(1'b1, 8'hA0, 8'h66, 1, "R10 unprotected write");
    wait_write();
    wp = 1'b1;
    do_write(1'b1, 8'hA0, 8'h99, 1, "R10 protected write");
    poll(1'b1, "R10 blocked write starts no cycle");
    expect_byte(8'h66, "R10 upper half kept");
    do_read(1'b1, 1'b1, 8'hA0, 1, "R10");
    do_write(1'b0, 8'hA0, 8'h5A, 1, "R10 lower write under wp");
    poll(1'b0, "R10 lower write busy");
    wait_write();
    expect_byte(8'h5A, "R10 lower half stored");
    do_read(1'b1, 1'b0, 8'hA0, 1, "R10");
    wp = 1'b0;
    do_write(1'b1, 8'hA0, 8'h99, 1, "R10 wp released");
    wait_write();
    expect_byte(8'h99, "R10 upper stored after release");
    do_read(1'b1, 1'b1, 8'hA0, 1, "R10");

    repeat (20) @(negedge clk);
    if (exp_q.size() != 0) begin
      checks++;
      fails++;
      $display("FAIL scoreboard: got %0d pending expected 0", exp_q.size());
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule